// File: doc/BRIEF.md
# Synchronous Bus Register Peripheral Node

This block is the peripheral side of a single-clock bus with no acknowledge path. A controller places an address, a direction bit and, for writes, a data word on the bus after the rising clock edge and holds them for the whole cycle. The block contains a shared address decoder and a parameterised number of identical register-file devices. Each device owns a window of the 16-bit address space and holds sixteen 16-bit words.

The low half of the clock is the peripheral phase. At the falling edge every device captures its decoded select, the register index, the direction and the write word. A selected device that sees a read turns on its data driver for the rest of the low half and presents the addressed word. A selected device that sees a write stores the captured word into the addressed register at the next rising edge. Outside that window a device drives nothing.

Each device's output enable is a port of its own. The data port carries the OR of all device outputs, and a device output is zero while its enable is off. The enables therefore model tri-state drivers on the shared data lines, and the data port models the bus with a released value of zero. The block never signals completion or failure and cannot stretch a cycle.

Top module: `sbus_periph_node`

## Requirements
- R1: While `rst_n` is low, and right after it rises, every register of every device reads as zero and no `dev_oe` bit is set, even with a read to a mapped address on the bus.
- R2: While `clk` is high, every `dev_oe` bit is 0. A write cycle (`bus_rnw` = 0) never sets any `dev_oe` bit.
- R3: Device k answers when `bus_addr[15:4]` equals bits 15:4 of `BASE + k*STRIDE`, and `bus_addr[3:0]` picks one of its 16 registers. Addresses that fall inside a stride but beyond the 16 registers select no device.
- R4: In a read cycle (`bus_rnw` = 1) to a mapped address, only `dev_oe[k]` of the selected device is 1 during the low half of the clock, and `rd_data` equals the addressed register.
- R5: In a write cycle, the word on `bus_wdata` is captured at the falling edge and stored at the next rising edge, so a read in the very next cycle returns it.
- R6: A cycle to an address outside every device window sets no `dev_oe` bit, leaves `rd_data` at zero, and changes no register.
- R7: At most one `dev_oe` bit is set at any time.
- R8: A write changes only the addressed register of the addressed device. The same index in other devices and the other registers keep their values.
- R9: `rd_data` is all-zero whenever no `dev_oe` bit is set (released bus).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; the rising edge opens a cycle, the low half is the peripheral phase |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Address lines driven by the controller |
| bus_rnw | input | 1 | Direction: 1 = read, 0 = write |
| bus_wdata | input | DATA_W | Data lines as driven by the controller in a write |
| dev_oe | output | NUM_DEV | Per-device data driver enable |
| rd_data | output | DATA_W | Merged device output onto the data lines, zero when released |

## Verification
The bench builds the block with three devices at base 0x8000 and a stride of 0x20, and selects the AND-OR read multiplexer. The stride is twice the register window, so every device window is followed by a 16-address gap that decodes to no device, and the unmapped-address and decode-boundary cases sit right beside legal addresses. Three devices also make it possible to show that a write to one index leaves the same index in both neighbours untouched. A behavioural model of the register contents is compared against both halves of every clock cycle.

// File: rtl/sbus_periph_pkg.sv
package sbus_periph_pkg;

   // Direction bit encoding on the bus
   typedef enum logic {
      XFER_WRITE = 1'b0,
      XFER_READ  = 1'b1
   } xfer_dir_e;

   // Start address of device k inside the address map
   function automatic int unsigned dev_base(input int unsigned base,
                                            input int unsigned stride,
                                            input int unsigned k);
      return base + k * stride;
   endfunction

endpackage

// File: rtl/sbus_addr_decoder.sv
module sbus_addr_decoder
   import sbus_periph_pkg::*;
#(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned REG_AW  = 4,
   parameter int unsigned NUM_DEV = 2,
   parameter int unsigned BASE    = 32'h4000,
   parameter int unsigned STRIDE  = 32'h0100
) (
   input  logic [ADDR_W-1:0]  addr_i,
   output logic [NUM_DEV-1:0] sel_o,
   output logic [REG_AW-1:0]  idx_o
);

   localparam int unsigned TAG_W = ADDR_W - REG_AW;

   // Elaboration-time configuration checks
   if (ADDR_W > 32 || REG_AW >= ADDR_W) begin : g_bad_width
      $error("sbus_addr_decoder: ADDR_W must be <= 32 and exceed REG_AW");
   end
   if ((BASE % (1 << REG_AW)) != 0 || (STRIDE % (1 << REG_AW)) != 0) begin : g_bad_align
      $error("sbus_addr_decoder: BASE and STRIDE must be aligned to the register window");
   end
   if (STRIDE < (1 << REG_AW)) begin : g_bad_overlap
      $error("sbus_addr_decoder: STRIDE smaller than the register window overlaps devices");
   end
   if (64'(dev_base(BASE, STRIDE, NUM_DEV - 1)) + 64'(1 << REG_AW) > (64'd1 << ADDR_W)) begin : g_bad_span
      $error("sbus_addr_decoder: device windows exceed the address space");
   end

   assign idx_o = addr_i[REG_AW-1:0];

   for (genvar k = 0; k < NUM_DEV; k++) begin : g_match
      localparam int unsigned DEV_START = dev_base(BASE, STRIDE, k);
      localparam logic [TAG_W-1:0] DEV_TAG = TAG_W'(DEV_START >> REG_AW);
      assign sel_o[k] = (addr_i[ADDR_W-1:REG_AW] == DEV_TAG);
   end

endmodule

// File: rtl/sbus_regfile_dev.sv
module sbus_regfile_dev
   import sbus_periph_pkg::*;
#(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned REG_AW      = 4,
   parameter bit          AND_OR_READ = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_i,
   input  logic [REG_AW-1:0] idx_i,
   input  logic              rnw_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              oe_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              sel_q_o
);

   localparam int unsigned DEPTH = 1 << REG_AW;

   if (DATA_W == 0 || REG_AW == 0 || REG_AW > 8) begin : g_bad_cfg
      $error("sbus_regfile_dev: DATA_W must be nonzero and REG_AW in 1..8");
   end

   // Peripheral-phase capture (falling edge)
   logic              sel_q;
   xfer_dir_e         dir_q;
   logic [REG_AW-1:0] idx_q;
   logic [DATA_W-1:0] wdata_q;
   logic              wr_q;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= 1'b0;
         dir_q   <= XFER_WRITE;
         idx_q   <= '0;
         wdata_q <= '0;
      end else begin
         sel_q   <= sel_i;
         dir_q   <= xfer_dir_e'(rnw_i);
         idx_q   <= idx_i;
         wdata_q <= wdata_i;
      end
   end

   assign wr_q    = sel_q && (dir_q == XFER_WRITE);
   assign sel_q_o = sel_q;

   // Register storage, committed on the rising edge that ends the cycle
   logic [DEPTH-1:0][DATA_W-1:0] regs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         regs <= '0;
      end else if (wr_q) begin
         regs[idx_q] <= wdata_q;
      end
   end

   // Read selection: two variants chosen by parameter
   logic [DATA_W-1:0] word;

   if (AND_OR_READ) begin : g_andor_read
      logic [DEPTH-1:0][DATA_W-1:0] terms;
      for (genvar r = 0; r < DEPTH; r++) begin : g_term
         assign terms[r] = (idx_q == REG_AW'(r)) ? regs[r] : '0;
      end
      always_comb begin
         word = '0;
         for (int r = 0; r < DEPTH; r++) begin
            word = word | terms[r];
         end
      end
   end else begin : g_index_read
      assign word = regs[idx_q];
   end

   // Driver enable only in the low half, when selected for a read
   assign oe_o    = !clk && sel_q && (dir_q == XFER_READ);
   assign rdata_o = oe_o ? word : '0;

   // R5: a captured write lands in the addressed register at the rising edge
   a_r5_write_commit: assert property (@(posedge clk) disable iff (!rst_n)
      wr_q |=> (regs[$past(idx_q)] == $past(wdata_q)));

   // R8: without a captured write the contents do not move
   a_r8_hold_contents: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_q |=> $stable(regs));

endmodule

// File: rtl/sbus_data_merge.sv
module sbus_data_merge #(
   parameter int unsigned NUM_SRC = 2,
   parameter int unsigned DATA_W  = 16
) (
   input  logic [NUM_SRC-1:0][DATA_W-1:0] src_i,
   output logic [DATA_W-1:0]              bus_o
);

   if (NUM_SRC == 0) begin : g_bad_cfg
      $error("sbus_data_merge: NUM_SRC must be nonzero");
   end

   // Released sources present zero, so OR models the wired bus
   always_comb begin
      bus_o = '0;
      for (int s = 0; s < NUM_SRC; s++) begin
         bus_o = bus_o | src_i[s];
      end
   end

endmodule

// File: rtl/sbus_periph_node.sv
module sbus_periph_node
   import sbus_periph_pkg::*;
#(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned REG_AW      = 4,
   parameter int unsigned NUM_DEV     = 2,
   parameter int unsigned BASE        = 32'h4000,
   parameter int unsigned STRIDE      = 32'h0100,
   parameter bit          AND_OR_READ = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_rnw,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [NUM_DEV-1:0] dev_oe,
   output logic [DATA_W-1:0]  rd_data
);

   if (NUM_DEV == 0 || NUM_DEV > 64) begin : g_bad_count
      $error("sbus_periph_node: NUM_DEV must be in 1..64");
   end

   logic [NUM_DEV-1:0]             dec_sel;
   logic [REG_AW-1:0]              dec_idx;
   logic [NUM_DEV-1:0]             dev_sel_q;
   logic [NUM_DEV-1:0][DATA_W-1:0] dev_rdata;

   sbus_addr_decoder #(
      .ADDR_W  (ADDR_W),
      .REG_AW  (REG_AW),
      .NUM_DEV (NUM_DEV),
      .BASE    (BASE),
      .STRIDE  (STRIDE)
   ) u_decoder (
      .addr_i (bus_addr),
      .sel_o  (dec_sel),
      .idx_o  (dec_idx)
   );

   for (genvar k = 0; k < NUM_DEV; k++) begin : g_dev
      sbus_regfile_dev #(
         .DATA_W      (DATA_W),
         .REG_AW      (REG_AW),
         .AND_OR_READ (AND_OR_READ)
      ) u_dev (
         .clk     (clk),
         .rst_n   (rst_n),
         .sel_i   (dec_sel[k]),
         .idx_i   (dec_idx),
         .rnw_i   (bus_rnw),
         .wdata_i (bus_wdata),
         .oe_o    (dev_oe[k]),
         .rdata_o (dev_rdata[k]),
         .sel_q_o (dev_sel_q[k])
      );
   end

   sbus_data_merge #(
      .NUM_SRC (NUM_DEV),
      .DATA_W  (DATA_W)
   ) u_merge (
      .src_i (dev_rdata),
      .bus_o (rd_data)
   );

   // R7: captured selects of separate devices never overlap
   a_r7_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dev_sel_q));

   // R6: an address outside every window leaves all devices unselected
   a_r6_unmapped_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_sel == '0) |-> (dev_sel_q == '0));

endmodule

// File: tb/test_sbus_periph_node.sv
`timescale 1ns/1ps
module test_sbus_periph_node;

   localparam int unsigned NDEV   = 3;
   localparam int unsigned BASE   = 32'h8000;
   localparam int unsigned STRIDE = 32'h0020;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [15:0]       bus_addr = 16'h0000;
   logic              bus_rnw = 1'b1;
   logic [15:0]       bus_wdata = 16'h0000;
   logic [NDEV-1:0]   dev_oe;
   logic [15:0]       rd_data;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;
   int unsigned ref_mem [NDEV][16];

   always #4 clk = ~clk;   // 125 MHz

   sbus_periph_node #(
      .ADDR_W      (16),
      .DATA_W      (16),
      .REG_AW      (4),
      .NUM_DEV     (NDEV),
      .BASE        (BASE),
      .STRIDE      (STRIDE),
      .AND_OR_READ (1'b1)
   ) i_sbus_periph_node (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_rnw   (bus_rnw),
      .bus_wdata (bus_wdata),
      .dev_oe    (dev_oe),
      .rd_data   (rd_data)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic int dev_of(input logic [15:0] a);
      for (int k = 0; k < NDEV; k++) begin
         if (a[15:4] == 12'((BASE + k * STRIDE) >> 4)) return k;
      end
      return -1;
   endfunction

   function automatic logic [15:0] dev_addr(input int k, input int r);
      return 16'(BASE + k * STRIDE + r);
   endfunction

   task automatic clear_model();
      for (int k = 0; k < NDEV; k++)
         for (int r = 0; r < 16; r++) ref_mem[k][r] = 0;
   endtask

   // One bus cycle, compared in the high half and in the low half
   task automatic bus_cycle(input logic [15:0] a, input bit rnw, input logic [15:0] d);
      int k;
      logic [NDEV-1:0] exp_oe;
      logic [15:0] exp_data;
      @(posedge clk);
      #1;
      bus_addr = a; bus_rnw = rnw; bus_wdata = d;
      #1;
      check("R2 high half enables released", 32'(dev_oe), 32'(0));
      check("R9 released bus reads zero", 32'(rd_data), 32'(0));
      @(negedge clk);
      #2;
      k = dev_of(a);
      exp_oe = '0;
      exp_data = '0;
      if (k >= 0 && rnw) begin
         exp_oe[k] = 1'b1;
         exp_data = 16'(ref_mem[k][a[3:0]]);
      end
      check("R7 enable count", 32'($countones(dev_oe)), 32'($countones(exp_oe)));
      if (k < 0) begin
         check("R6 unmapped enables", 32'(dev_oe), 32'(exp_oe));
         check("R6 unmapped data", 32'(rd_data), 32'(exp_data));
      end else if (rnw) begin
         check("R3 R4 read enable", 32'(dev_oe), 32'(exp_oe));
         check("R4 R5 R8 read data", 32'(rd_data), 32'(exp_data));
      end else begin
         check("R2 write never drives", 32'(dev_oe), 32'(exp_oe));
         check("R9 write data released", 32'(rd_data), 32'(exp_data));
         ref_mem[k][a[3:0]] = d;
      end
   endtask

   task automatic read_all();
      for (int k = 0; k < NDEV; k++)
         for (int r = 0; r < 16; r++) bus_cycle(dev_addr(k, r), 1'b1, 16'hFFFF);
   endtask

   initial begin
      #(8 * 20000);
      n_err++;
      $display("FAIL watchdog R1..: actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      clear_model();
      // R1: read to a mapped address during reset, in the low half
      bus_addr = dev_addr(1, 3); bus_rnw = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk); #2;
      check("R1 no drive in reset", 32'(dev_oe), 32'(0));
      check("R1 no data in reset", 32'(rd_data), 32'(0));
      @(posedge clk); #1 rst_n = 1'b1;

      // R1: all registers zero after reset
      read_all();

      // R5 R8: walking patterns into every register
      for (int k = 0; k < NDEV; k++)
         for (int r = 0; r < 16; r++)
            bus_bus_write(k, r);
      read_all();

      // R5: write immediately followed by a read of the same location
      bus_cycle(dev_addr(2, 9), 1'b0, 16'h1234);
      bus_cycle(dev_addr(2, 9), 1'b1, 16'h0000);
      bus_cycle(dev_addr(0, 0), 1'b0, 16'hFFFF);
      bus_cycle(dev_addr(0, 0), 1'b0, 16'h0001);
      bus_cycle(dev_addr(0, 0), 1'b1, 16'h0000);

      // R8: same index in neighbouring devices stays put
      bus_cycle(dev_addr(1, 7), 1'b0, 16'hBEEF);
      bus_cycle(dev_addr(0, 7), 1'b1, 16'h0000);
      bus_cycle(dev_addr(2, 7), 1'b1, 16'h0000);
      bus_cycle(dev_addr(1, 7), 1'b1, 16'h0000);
      bus_cycle(dev_addr(1, 6), 1'b1, 16'h0000);
      bus_cycle(dev_addr(1, 8), 1'b1, 16'h0000);

      // R3 R6: gaps inside strides and far addresses
      bus_cycle(16'h8010, 1'b0, 16'hDEAD);
      bus_cycle(16'h803F, 1'b0, 16'hDEAD);
      bus_cycle(16'h8060, 1'b0, 16'hDEAD);
      bus_cycle(16'h7FFF, 1'b0, 16'hDEAD);
      bus_cycle(16'h0005, 1'b0, 16'hDEAD);
      bus_cycle(16'hFFFF, 1'b0, 16'hDEAD);
      bus_cycle(16'h8010, 1'b1, 16'h0000);
      bus_cycle(16'h805F, 1'b1, 16'h0000);
      bus_cycle(16'h0000, 1'b1, 16'h0000);
      read_all();

      // R1: reset in the middle of operation clears contents
      @(posedge clk); #1 rst_n = 1'b0;
      clear_model();
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
      read_all();

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   task automatic bus_bus_write(input int k, input int r);
      bus_cycle(dev_addr(k, r), 1'b0, 16'((k << 12) ^ (r * 16'h1111) ^ 16'hA5A5));
   endtask

endmodule